// File: doc/BRIEF.md
# Round-Robin Multi-Channel Transmit Scheduler

This block sits between software-facing byte streams and a single shared transmit FIFO. Each of `NCH` channels owns a small circular byte buffer. A producer pushes up to four bytes per cycle into one channel, and the block reports how many bytes it took. Each cycle the scheduler picks one channel that holds data and packs up to four of its oldest bytes into a 32-bit self-describing word. It hands that word, tagged with the channel number, to the FIFO. The FIFO itself is outside the block.

The word format lets any one, two or three bytes, and most four-byte groups, travel in one word. Marker values in the upper bytes tell a receiver how many bytes are valid. When four raw bytes would look like a marker, the packer sends three bytes and leaves the fourth for the next word. Channels are served fairly. A saved next-channel index moves on only after its channel has actually issued a word. Each channel has a hangup input that discards its buffered bytes, and the block reports per-channel occupancy and a global count of pending bytes.

`rst_n` is asserted asynchronously. Its deassertion is expected to be already synchronised to `clk`. `FIFO_DEPTH` must be a power of two, so each buffer (four times that depth, in bytes) wraps naturally.

Top module: `txs_sched`

## Requirements
- R1: A write takes `min(L, 4*FIFO_DEPTH - count)` bytes, where L is `wr_len` clipped to 4. It takes 0 bytes when `wr_valid` is low or when that channel's hangup is high. The byte count is reported on `wr_taken` in the same cycle. Bytes are accepted from `wr_data[7:0]` upward, and the lowest byte is the oldest.
- R2: The packed word holds the oldest bytes b0..b2 as follows. One byte is packed as `0x808080_b0`, two as `0x8181_b1_b0`, and three as `0x82_b2_b1_b0`, with b0 always in bits 7:0.
- R3: With four or more bytes buffered, the word is the raw `b3_b2_b1_b0`. The exception is when bits 31:8 equal 0x808080, bits 31:16 equal 0x8181, or bits 31:24 equal 0x82. In that case the three-byte form is sent and exactly three bytes are consumed.
- R4: While `fifo_full` is high, no word is pushed. With no write and no hangup, every channel count and the pending total hold their values.
- R5: The granted channel (`fifo_chan`) is the first channel, scanning upward from the saved index and wrapping from NCH-1 to 0, that has a nonzero count and no hangup. After a push, the saved index becomes grant+1, wrapping to 0. Without a push it is unchanged.
- R6: A channel's bytes leave in the order they were written, including words that straddle the buffer's wrap point.
- R7: A hangup clears the channel's count to zero on the next cycle and removes its bytes from the pending total. A write to that channel in the same cycle is refused, and the channel is not granted in that cycle.
- R8: `pend_total` always equals the sum of all channel counts. No word is pushed while it is zero.
- R9: After reset all counts and `pend_total` are zero, every `ch_empty` bit is high and `fifo_push` is low. `ch_empty[c]` is high exactly when channel c's count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Write request this cycle |
| wr_chan | input | log2(NCH) | Channel to write |
| wr_len | input | 3 | Bytes offered (values above 4 act as 4) |
| wr_data | input | 32 | Offered bytes, oldest in bits 7:0 |
| wr_taken | output | 3 | Bytes accepted this cycle |
| hangup | input | NCH | Per-channel discard request |
| fifo_full | input | 1 | Downstream FIFO cannot accept a word |
| fifo_push | output | 1 | Word valid, written into the FIFO at the clock edge |
| fifo_chan | output | log2(NCH) | Channel that the word belongs to |
| fifo_word | output | 32 | Packed word |
| ch_count | output | NCH*log2(4*FIFO_DEPTH+1) | Per-channel buffered byte counts, channel c at slice c |
| ch_empty | output | NCH | Per-channel drained flag, used to wait for shutdown |
| pend_total | output | log2(NCH*4*FIFO_DEPTH+1) | Bytes pending over all channels |

## Verification
The assertions assume `fifo_full` is a truthful level from the consumer. They do not assume it is stable or bears any relation to what the block pushed, so the bench toggles it freely, sometimes for long runs that let buffers fill to the brim. They also assume the producer may offer any length and channel, including writes to a full channel and writes that collide with a hangup. The stimulus therefore draws lengths 0 to 7, every channel, rare single hangups and data biased towards the marker bytes 0x80 to 0x83. No input constraint beyond a synchronised reset release is needed for the properties to hold.

// File: rtl/txs_pkg.sv
package txs_pkg;
  // byte lanes per packed word
  localparam int LANES = 4;
  // length markers carried in the upper bytes of a packed word
  localparam logic [23:0] TAG1 = 24'h808080;
  localparam logic [15:0] TAG2 = 16'h8181;
  localparam logic [7:0]  TAG3 = 8'h82;
  typedef logic [2:0] nbyte_t;
endpackage

// File: rtl/txs_word_pack.sv
module txs_word_pack
  import txs_pkg::*;
(
  input  logic [31:0] bytes,
  input  nbyte_t      avail,
  output logic [31:0] word,
  output nbyte_t      used
);
  logic clash;

  always_comb begin : pack
    clash = (bytes[31:8] == TAG1) || (bytes[31:16] == TAG2) || (bytes[31:24] == TAG3);
    used  = avail;
    word  = '0;
    case (avail)
      3'd1: word = {TAG1, bytes[7:0]};
      3'd2: word = {TAG2, bytes[15:0]};
      3'd3: word = {TAG3, bytes[23:0]};
      3'd4: begin
        if (clash) begin
          word = {TAG3, bytes[23:0]};
          used = 3'd3;
        end else begin
          word = bytes;
        end
      end
      default: used = '0;
    endcase
  end
endmodule

// File: rtl/txs_rr_pick.sv
module txs_rr_pick #(
  parameter  int N  = 16,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] start,
  output logic          any,
  output logic [IW-1:0] grant
);
  always_comb begin : scan
    int idx;
    idx   = 0;
    any   = |req;
    grant = start;
    // descending offset so the nearest requester at or after start wins
    for (int k = N - 1; k >= 0; k--) begin
      idx = (int'(start) + k) % N;
      if (req[idx]) grant = IW'(idx);
    end
  end
endmodule

// File: rtl/txs_chan_buf.sv
module txs_chan_buf
  import txs_pkg::*;
#(
  parameter  int DEPTH = 16,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  nbyte_t        wr_n,
  input  logic [31:0]   wr_bytes,
  input  nbyte_t        rd_n,
  output logic [CW-1:0] count,
  output logic [31:0]   peek
);
  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] head_q, head_d, tail_q, tail_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          upd;

  always_comb begin : next_state
    upd   = flush || (wr_n != '0) || (rd_n != '0);
    cnt_d = flush ? '0 : cnt_q + CW'(wr_n) - CW'(rd_n);
    if (cnt_d == '0) begin
      // drained: both pointers return to the start
      head_d = '0;
      tail_d = '0;
    end else begin
      head_d = head_q + AW'(wr_n);
      tail_d = tail_q + AW'(rd_n);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin : regs
    if (!rst_n) begin
      cnt_q  <= '0;
      head_q <= '0;
      tail_q <= '0;
    end else if (upd) begin
      cnt_q  <= cnt_d;
      head_q <= head_d;
      tail_q <= tail_d;
    end
  end

  always_ff @(posedge clk) begin : store
    for (int i = 0; i < LANES; i++) begin
      if (!flush && (nbyte_t'(i) < wr_n)) mem[head_q + AW'(i)] <= wr_bytes[8*i +: 8];
    end
  end

  always_comb begin : look
    for (int i = 0; i < LANES; i++) peek[8*i +: 8] = mem[tail_q + AW'(i)];
  end

  assign count = cnt_q;

  p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
  p_rd_le_cnt_r3: assert property (@(posedge clk) disable iff (!rst_n)
    CW'(rd_n) <= cnt_q);
  p_flush_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (cnt_q == '0));
endmodule

// File: rtl/txs_sched.sv
module txs_sched
  import txs_pkg::*;
#(
  parameter  int NCH        = 16,
  parameter  int FIFO_DEPTH = 4,
  localparam int DEPTH      = 4 * FIFO_DEPTH,
  localparam int CW         = $clog2(DEPTH + 1),
  localparam int CHW        = $clog2(NCH),
  localparam int TW         = $clog2(NCH * DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [CHW-1:0]    wr_chan,
  input  logic [2:0]        wr_len,
  input  logic [31:0]       wr_data,
  output logic [2:0]        wr_taken,
  input  logic [NCH-1:0]    hangup,
  input  logic              fifo_full,
  output logic              fifo_push,
  output logic [CHW-1:0]    fifo_chan,
  output logic [31:0]       fifo_word,
  output logic [NCH*CW-1:0] ch_count,
  output logic [NCH-1:0]    ch_empty,
  output logic [TW-1:0]     pend_total
);
  logic [CW-1:0]  cnt  [NCH];
  logic [31:0]    peek [NCH];
  logic [NCH-1:0] req;
  logic           any_req, issue, tot_en;
  logic [CHW-1:0] grant, nxt_q, nxt_d;
  logic [TW-1:0]  tot_q, tot_d, drop;
  logic [CW-1:0]  room, gcnt;
  nbyte_t         len_c, take, avail, used;
  logic [31:0]    word;

  always_comb begin : acceptance
    len_c = (wr_len > 3'd4) ? 3'd4 : wr_len;
    room  = CW'(DEPTH) - cnt[wr_chan];
    take  = '0;
    if (wr_valid && !hangup[wr_chan]) take = (CW'(len_c) > room) ? room[2:0] : len_c;
  end

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    nbyte_t wn, rn;
    assign wn     = (wr_chan == CHW'(g)) ? take : '0;
    assign rn     = (issue && grant == CHW'(g)) ? used : '0;
    assign req[g] = (cnt[g] != '0) && !hangup[g];
    txs_chan_buf #(.DEPTH(DEPTH)) u_buf (
      .clk      (clk),
      .rst_n    (rst_n),
      .flush    (hangup[g]),
      .wr_n     (wn),
      .wr_bytes (wr_data),
      .rd_n     (rn),
      .count    (cnt[g]),
      .peek     (peek[g])
    );
    assign ch_count[g*CW +: CW] = cnt[g];
    assign ch_empty[g]          = (cnt[g] == '0);
  end

  txs_rr_pick #(.N(NCH)) u_pick (
    .req   (req),
    .start (nxt_q),
    .any   (any_req),
    .grant (grant)
  );

  always_comb begin : issue_logic
    gcnt  = cnt[grant];
    avail = (gcnt > CW'(4)) ? 3'd4 : gcnt[2:0];
    issue = (tot_q != '0) && !fifo_full && any_req;
  end

  txs_word_pack u_pack (
    .bytes (peek[grant]),
    .avail (avail),
    .word  (word),
    .used  (used)
  );

  always_comb begin : next_state
    drop = '0;
    for (int c = 0; c < NCH; c++) if (hangup[c]) drop = drop + TW'(cnt[c]);
    tot_en = (take != '0) || issue || (hangup != '0);
    tot_d  = tot_q + TW'(take) - (issue ? TW'(used) : '0) - drop;
    nxt_d  = nxt_q;
    if (issue) nxt_d = (grant == CHW'(NCH - 1)) ? '0 : grant + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin : regs
    if (!rst_n) begin
      tot_q <= '0;
      nxt_q <= '0;
    end else begin
      if (tot_en) tot_q <= tot_d;
      if (issue)  nxt_q <= nxt_d;
    end
  end

  assign wr_taken   = take;
  assign fifo_push  = issue;
  assign fifo_chan  = grant;
  assign fifo_word  = word;
  assign pend_total = tot_q;

  logic [TW-1:0] cnt_sum;
  always_comb begin : sum_chk
    cnt_sum = '0;
    for (int c = 0; c < NCH; c++) cnt_sum = cnt_sum + TW'(cnt[c]);
  end

  p_total_sum_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tot_q == cnt_sum);
  p_idle_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tot_q == '0) |-> !fifo_push);
  p_hold_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_full && !wr_valid && hangup == '0) |=> ($stable(ch_count) && $stable(tot_q)));
  p_push_nonempty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_push |-> (cnt[fifo_chan] != '0 && !hangup[fifo_chan]));
  p_used_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_push |-> (used != '0 && used <= avail));
endmodule

// File: tb/sim_txs_sched.sv
module sim_txs_sched;
  localparam int NCH = 16, FD = 4, DEP = 16, CW = 5, TW = 9;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, wr_valid, fifo_full, fifo_push;
  logic [3:0] wr_chan, fifo_chan;
  logic [2:0] wr_len, wr_taken;
  logic [31:0] wr_data, fifo_word;
  logic [15:0] hangup, ch_empty;
  logic [NCH*CW-1:0] ch_count;
  logic [TW-1:0] pend_total;

  txs_sched #(.NCH(NCH), .FIFO_DEPTH(FD)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_chan(wr_chan), .wr_len(wr_len),
    .wr_data(wr_data), .wr_taken(wr_taken), .hangup(hangup), .fifo_full(fifo_full),
    .fifo_push(fifo_push), .fifo_chan(fifo_chan), .fifo_word(fifo_word),
    .ch_count(ch_count), .ch_empty(ch_empty), .pend_total(pend_total));

  int nchk = 0, nfail = 0, cyc = 0;
  bit done = 0;
  logic [7:0] mq [NCH][DEP];
  int mc [NCH];
  int mnxt = 0, mtot = 0;
  logic obs_push;
  logic [3:0] obs_chan;
  logic [31:0] obs_word;
  int obs_taken;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic int cnt_of(int c);
    return int'(ch_count[c*CW +: CW]);
  endfunction

  function automatic logic [31:0] xs(logic [31:0] x);
    x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
    return x;
  endfunction

  function automatic void enc(input logic [31:0] raw, input int av, output logic [31:0] w, output int u);
    u = av;
    case (av)
      1: w = {24'h808080, raw[7:0]};
      2: w = {16'h8181, raw[15:0]};
      3: w = {8'h82, raw[23:0]};
      default: begin
        if (raw[31:8] == 24'h808080 || raw[31:16] == 16'h8181 || raw[31:24] == 8'h82) begin
          w = {8'h82, raw[23:0]}; u = 3;
        end else w = raw;
      end
    endcase
  endfunction

  // one cycle: predict outputs, sample mid-low-phase, update model at the edge
  task automatic step();
    int tk, g, av, u, wc;
    bit iss;
    logic [31:0] w, raw;
    #1;
    wc = int'(wr_chan);
    tk = 0;
    if (wr_valid && !hangup[wc]) begin
      tk = (wr_len > 3'd4) ? 4 : int'(wr_len);
      if (tk > DEP - mc[wc]) tk = DEP - mc[wc];
    end
    check(int'(wr_taken) == tk, "R1 accepted bytes", wr_taken, tk);
    iss = 0; g = 0;
    if (mtot != 0 && !fifo_full)
      for (int k = 0; k < NCH; k++) begin
        int c;
        c = (mnxt + k) % NCH;
        if (!iss && mc[c] != 0 && !hangup[c]) begin iss = 1; g = c; end
      end
    check(fifo_push == iss, "R4 R8 push", fifo_push, iss);
    obs_push = fifo_push; obs_chan = fifo_chan; obs_word = fifo_word; obs_taken = int'(wr_taken);
    u = 0;
    if (iss) begin
      av  = (mc[g] > 4) ? 4 : mc[g];
      raw = {mq[g][3], mq[g][2], mq[g][1], mq[g][0]};
      enc(raw, av, w, u);
      check(fifo_chan == 4'(g), "R5 granted channel", fifo_chan, g);
      check(fifo_word == w, "R2 R3 R6 packed word", fifo_word, w);
    end
    @(posedge clk);
    for (int c = 0; c < NCH; c++) if (hangup[c]) begin mtot -= mc[c]; mc[c] = 0; end
    if (iss) begin
      for (int i = 0; i < DEP; i++) mq[g][i] = (i + u < DEP) ? mq[g][i+u] : 8'h00;
      mc[g] -= u; mtot -= u; mnxt = (g + 1) % NCH;
    end
    for (int i = 0; i < tk; i++) mq[wc][mc[wc]+i] = wr_data[8*i +: 8];
    mc[wc] += tk; mtot += tk;
    @(negedge clk);
    for (int c = 0; c < NCH; c++) check(cnt_of(c) == mc[c], "R7 channel count", cnt_of(c), mc[c]);
    for (int c = 0; c < NCH; c++) check(ch_empty[c] == (mc[c] == 0), "R9 empty flag", ch_empty[c], mc[c] == 0);
    check(int'(pend_total) == mtot, "R8 pending total", pend_total, mtot);
  endtask

  task automatic send(int ch, int len, logic [31:0] d);
    wr_valid = 1'b1; wr_chan = 4'(ch); wr_len = 3'(len); wr_data = d;
    step();
    wr_valid = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
  endtask

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc == 150000 && !done) begin
      nfail++;
      $display("FAIL watchdog act=%0d exp=finished", cyc);
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] r1, r2;
    r1 = 32'h1234_5677; r2 = 32'h89ab_cdef;
    for (int c = 0; c < NCH; c++) begin
      mc[c] = 0;
      for (int i = 0; i < DEP; i++) mq[c][i] = 8'h00;
    end
    rst_n = 1'b0; wr_valid = 1'b0; wr_chan = '0; wr_len = '0; wr_data = '0;
    hangup = '0; fifo_full = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R9 reset state
    check(ch_count == '0, "R9 reset counts", ch_count, 0);
    check(ch_empty == 16'hFFFF, "R9 reset empty", ch_empty, 16'hFFFF);
    check(fifo_push == 1'b0, "R9 reset push", fifo_push, 0);
    check(pend_total == '0, "R9 reset total", pend_total, 0);

    // R2 / R3 encodings on channel 3
    fifo_full = 1; send(3, 1, 32'h0000_0041); fifo_full = 0; step();
    check(obs_word == 32'h8080_8041, "R2 one byte", obs_word, 32'h8080_8041);
    fifo_full = 1; send(3, 2, 32'h0000_4241); fifo_full = 0; step();
    check(obs_word == 32'h8181_4241, "R2 two bytes", obs_word, 32'h8181_4241);
    fifo_full = 1; send(3, 3, 32'h0043_4241); fifo_full = 0; step();
    check(obs_word == 32'h8243_4241, "R2 three bytes", obs_word, 32'h8243_4241);
    fifo_full = 1; send(3, 4, 32'h4443_4241); fifo_full = 0; step();
    check(obs_word == 32'h4443_4241, "R3 raw four", obs_word, 32'h4443_4241);
    fifo_full = 1; send(3, 4, 32'h8203_0201); fifo_full = 0; step();
    check(obs_word == 32'h8203_0201, "R3 clash top byte", obs_word, 32'h8203_0201);
    check(cnt_of(3) == 1, "R3 one byte left", cnt_of(3), 1);
    step();
    check(obs_word == 32'h8080_8082, "R3 leftover byte", obs_word, 32'h8080_8082);
    fifo_full = 1; send(3, 4, 32'h8080_8000); fifo_full = 0; step();
    check(obs_word == 32'h8280_8000, "R3 clash three markers", obs_word, 32'h8280_8000);
    step();

    // R5 round robin from saved index 4, wrapping past 15
    fifo_full = 1;
    send(2, 1, 32'hA2); send(5, 1, 32'hA5); send(15, 1, 32'hAF);
    fifo_full = 0;
    step(); check(obs_chan == 4'd5, "R5 first grant", obs_chan, 5);
    step(); check(obs_chan == 4'd15, "R5 second grant", obs_chan, 15);
    step(); check(obs_chan == 4'd2, "R5 wrap grant", obs_chan, 2);
    idle(2);

    // R1 capacity and R6 straddling the wrap point on channel 7
    fifo_full = 1;
    send(7, 4, 32'h8203_0201); send(7, 4, 32'h0706_0504);
    send(7, 4, 32'h0B0A_0908); send(7, 4, 32'h0F0E_0D0C);
    send(7, 4, 32'h9999_9999);
    check(obs_taken == 0, "R1 full buffer refuses", obs_taken, 0);
    fifo_full = 0; step();
    fifo_full = 1; send(7, 4, 32'h1312_1110);
    check(obs_taken == 3, "R1 partial accept", obs_taken, 3);
    fifo_full = 0; idle(3); step();
    check(obs_word == 32'h1211_100F, "R6 wrap word", obs_word, 32'h1211_100F);
    check(ch_empty[7] == 1'b1, "R6 drained", ch_empty[7], 1);

    // R7 hangup
    fifo_full = 1;
    send(9, 4, 32'h0403_0201); send(10, 2, 32'h0000_B2B1);
    hangup = 16'h0200; send(9, 4, 32'h1111_1111); hangup = '0;
    check(obs_taken == 0, "R7 write refused on hangup", obs_taken, 0);
    check(cnt_of(9) == 0, "R7 count cleared", cnt_of(9), 0);
    check(int'(pend_total) == 2, "R7 total reduced", pend_total, 2);
    fifo_full = 0; step();
    check(obs_chan == 4'd10, "R7 hung channel skipped", obs_chan, 10);
    check(obs_word == 32'h8181_B2B1, "R7 other channel word", obs_word, 32'h8181_B2B1);

    // pseudo-random sweep over all channels, lengths and full patterns
    for (int n = 0; n < 4000; n++) begin
      r1 = xs(r1); r2 = xs(r2);
      wr_valid = r1[0] | r1[1];
      wr_chan  = r1[7:4];
      wr_len   = r1[10:8];
      for (int i = 0; i < 4; i++)
        wr_data[8*i +: 8] = r2[2*i] ? (8'h80 + {6'd0, r2[9+2*i +: 2]}) : r1[8*i +: 8];
      hangup    = (r1[15:11] == 5'd0) ? (16'd1 << r1[19:16]) : 16'd0;
      fifo_full = (n < 2000) ? (r1[20] | r1[21]) : (r1[20] & r1[21]);
      step();
    end
    wr_valid = 0; hangup = '0; fifo_full = 0;
    idle(80);
    check(pend_total == '0, "R8 fully drained", pend_total, 0);

    done = 1;
    summary();
    $finish;
  end
endmodule